// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block produces the command sequence that brings a DDR2 SDRAM from its power-stable state into a state where normal traffic can begin. A single `start` pulse launches it. The block then walks a fixed list of eleven commands: precharge-all commands, refreshes, and loads of the four mode registers. Each command drives the chip-select, row-strobe, column-strobe, write-enable, bank-address and address pins for exactly one clock cycle. Between commands the block drives a NOP. When the last step has settled it raises `done`.

The content of every mode register is computed at elaboration from parameters: burst length, CAS latency, write recovery, drive strength, termination, additive latency and the other fields. The spacing between commands is a parameter counted in clock cycles. The default of 15 cycles matches 120 ns at 125 MHz. The wait for stable power before `start`, read-strobe calibration, the physical I/O and all normal read/write scheduling belong to other blocks.

Top module: `ddr2i_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` = 0, `cs_n` = 1, `ras_n`/`cas_n`/`we_n` = 1, `ba` = 0, `addr` = 0 and `done` = 0.
- R2: Without a `start` pulse after reset, no command is issued and `cs_n` stays 1. If `start` is sampled high at clock edge E0 while the block is idle, the first command is on the pins for the one cycle that follows edge E0+1. In that first cycle after E0 the pins still show the idle state.
- R3: The commands come in this order: precharge-all, load MR2, load MR3, load MR1, load MR0, precharge-all, refresh, refresh, load MR0, load MR1, load MR1. The pin code {ras_n,cas_n,we_n} is 000 for a mode load, 001 for refresh, 010 for precharge and 111 for NOP.
- R4: Command k (k = 0..10) is driven in the cycle after edge E0+1+k·GAP_CYC. Every other cycle of the sequence is a NOP with `cs_n` = 0.
- R5: A precharge-all drives `addr` = 0x0400 (A10 set) and `ba` = 0.
- R6: MR0 loads use `ba` = 0. The field positions are: burst length in A2:0 (010 = 4), burst type in A3 (0 = sequential), CAS latency in A6:4 (011), test mode in A7 (0), DLL reset in A8, write recovery minus one in A11:9, and power-down exit in A12 (0 = fast). The first load is 0x0532, with DLL reset set. The second load is 0x0432, with DLL reset clear.
- R7: MR1 loads use `ba` = 1. All fields are zero except the off-chip-driver calibration field A9:7. That field is 000 (exit) in the first load and in the last load, and 111 (default) in the load just before the last, giving 0x0380.
- R8: The MR2 load uses `ba` = 2 and `addr` = 0, with A7 clear, which selects the 1X self-refresh rate. The MR3 load uses `ba` = 3 and `addr` = 0.
- R9: `done` rises GAP_CYC cycles after the last command, in the cycle after edge E0+1+11·GAP_CYC. It then stays 1 until reset, and the pins stay at NOP with `cs_n` = 0.
- R10: A `start` pulse during the sequence or after `done` has no effect on the pins or on the timing.
- R11: `cke` is 1 from the first clock edge after reset is released, and it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence when sampled high while idle |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the mode register on a load |
| addr | output | ADDR_W | Address bus; carries mode fields and A10 |
| done | output | 1 | Sequence complete; held until reset |

## Verification
Everything in the block is timed from edge E0, the edge that samples `start`. A command or `done` change that the control logic decides at edge E0+n reaches the pins one edge later, through the output register. Command k is therefore due in the cycle after edge E0+1+k·GAP_CYC, and `done` is due after edge E0+1+11·GAP_CYC. The bench counts clock edges from E0 and samples on the falling edge in exactly those cycles. It also checks the first NOP slot after each command, the cycle just before `done` is due, and the cycle in which the first command is not yet visible, so that a shift of a single cycle in either direction is caught.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

  // {ras_n, cas_n, we_n} with cs_n low
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    MR_MAIN = 2'd0,
    MR_EXT1 = 2'd1,
    MR_EXT2 = 2'd2,
    MR_EXT3 = 2'd3
  } mr_sel_e;

  typedef enum logic [1:0] {
    OP_PRE  = 2'd0,
    OP_REF  = 2'd1,
    OP_LOAD = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

  typedef struct packed {
    op_kind_e kind;
    mr_sel_e  reg_sel;
    logic     dll_rst;   // MR0 only
    logic     ocd_dflt;  // MR1 only
  } step_t;

  localparam int NUM_STEPS = 11;
  localparam int MR_BITS   = 13;

  // Ordered step list of the power-up sequence
  function automatic step_t step_of(input int unsigned idx);
    step_t s;
    s = '{kind: OP_PRE, reg_sel: MR_MAIN, dll_rst: 1'b0, ocd_dflt: 1'b0};
    case (idx)
      0, 5:  s.kind = OP_PRE;
      1:     begin s.kind = OP_LOAD; s.reg_sel = MR_EXT2; end
      2:     begin s.kind = OP_LOAD; s.reg_sel = MR_EXT3; end
      3, 10: begin s.kind = OP_LOAD; s.reg_sel = MR_EXT1; end
      4:     begin s.kind = OP_LOAD; s.reg_sel = MR_MAIN; s.dll_rst = 1'b1; end
      6, 7:  s.kind = OP_REF;
      8:     begin s.kind = OP_LOAD; s.reg_sel = MR_MAIN; end
      9:     begin s.kind = OP_LOAD; s.reg_sel = MR_EXT1; s.ocd_dflt = 1'b1; end
      default: s.kind = OP_REF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr2i_gap_timer.sv
module ddr2i_gap_timer #(
  parameter int GAP_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= RELOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr2i_step_ctrl.sv
module ddr2i_step_ctrl
  import ddr2i_pkg::*;
#(
  parameter int STEPS = NUM_STEPS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         expired,
  output logic                         fire,
  output logic                         issue,
  output logic [$clog2(STEPS)-1:0]     step,
  output logic                         launched,
  output logic                         done
);
  localparam int SW = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  seq_state_e     st_q;
  logic [SW-1:0]  step_q;
  logic           issue_q;
  logic           done_q;
  logic           finish;

  always_comb begin
    fire   = 1'b0;
    finish = 1'b0;
    case (st_q)
      SQ_IDLE: fire = start;
      SQ_RUN: begin
        fire   = expired && (step_q != LAST);
        finish = expired && (step_q == LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      step_q  <= '0;
      issue_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      issue_q <= fire;
      if (st_q == SQ_IDLE && start) begin
        st_q   <= SQ_RUN;
        step_q <= '0;
      end else if (fire) begin
        step_q <= step_q + 1'b1;
      end else if (finish) begin
        st_q   <= SQ_DONE;
        done_q <= 1'b1;
      end
    end
  end

  assign issue    = issue_q;
  assign step     = step_q;
  assign launched = (st_q != SQ_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/ddr2i_mode_enc.sv
module ddr2i_mode_enc
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter int BURST_LEN    = 4,
  parameter bit BURST_INTLV  = 1'b0,
  parameter int CAS_LAT      = 3,
  parameter int WR_REC       = 3,
  parameter bit PD_SLOW_EXIT = 1'b0,
  parameter bit DLL_DISABLE  = 1'b0,
  parameter bit DRIVE_REDUCE = 1'b0,
  parameter logic [1:0] RTT_CODE = 2'b00,
  parameter int ADD_LAT      = 0,
  parameter bit DQSN_DISABLE = 1'b0,
  parameter bit RDQS_ENABLE  = 1'b0,
  parameter bit OUT_DISABLE  = 1'b0,
  parameter bit SRT_FAST     = 1'b0
) (
  input  step_t             step_info,
  output ddr_cmd_e          cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [2:0] BL_CODE = (BURST_LEN == 8) ? 3'b011 : 3'b010;
  localparam logic [2:0] CL_CODE = 3'(CAS_LAT);
  localparam logic [2:0] WR_CODE = 3'(WR_REC - 1);
  localparam logic [2:0] AL_CODE = 3'(ADD_LAT);

  localparam logic [MR_BITS-1:0] MR0_BASE =
    {PD_SLOW_EXIT, WR_CODE, 1'b0, 1'b0, CL_CODE, BURST_INTLV, BL_CODE};
  localparam logic [MR_BITS-1:0] MR1_BASE =
    {OUT_DISABLE, RDQS_ENABLE, DQSN_DISABLE, 3'b000, RTT_CODE[1],
     AL_CODE, RTT_CODE[0], DRIVE_REDUCE, DLL_DISABLE};
  localparam logic [MR_BITS-1:0] MR2_BASE = MR_BITS'({SRT_FAST, 7'b0});
  localparam logic [MR_BITS-1:0] A10_ONLY = MR_BITS'(1) << 10;

  logic [MR_BITS-1:0] word;

  always_comb begin
    word = '0;
    cmd  = CMD_REF;
    case (step_info.kind)
      OP_PRE: begin
        cmd  = CMD_PRE;
        word = A10_ONLY;
      end
      OP_LOAD: begin
        cmd = CMD_LMR;
        case (step_info.reg_sel)
          MR_MAIN: word = MR0_BASE | (MR_BITS'(step_info.dll_rst) << 8);
          MR_EXT1: word = MR1_BASE | ({MR_BITS{step_info.ocd_dflt}} & (MR_BITS'(7) << 7));
          MR_EXT2: word = MR2_BASE;
          default: word = '0;
        endcase
      end
      default: ;
    endcase
  end

  generate
    if (ADDR_W > MR_BITS) begin : g_addr_pad
      assign addr = {{(ADDR_W - MR_BITS){1'b0}}, word};
    end else begin : g_addr_fit
      assign addr = word;
    end
    if (BA_W > 2) begin : g_ba_pad
      assign ba = (step_info.kind == OP_LOAD) ? {{(BA_W - 2){1'b0}}, step_info.reg_sel} : '0;
    end else begin : g_ba_fit
      assign ba = (step_info.kind == OP_LOAD) ? step_info.reg_sel : '0;
    end
  endgenerate
endmodule

// File: rtl/ddr2i_init_seq.sv
module ddr2i_init_seq
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter int GAP_CYC      = 15,
  parameter int BURST_LEN    = 4,
  parameter bit BURST_INTLV  = 1'b0,
  parameter int CAS_LAT      = 3,
  parameter int WR_REC       = 3,
  parameter bit PD_SLOW_EXIT = 1'b0,
  parameter bit DLL_DISABLE  = 1'b0,
  parameter bit DRIVE_REDUCE = 1'b0,
  parameter logic [1:0] RTT_CODE = 2'b00,
  parameter int ADD_LAT      = 0,
  parameter bit DQSN_DISABLE = 1'b0,
  parameter bit RDQS_ENABLE  = 1'b0,
  parameter bit OUT_DISABLE  = 1'b0,
  parameter bit SRT_FAST     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int SW = $clog2(NUM_STEPS);

  logic          expired, fire, issue, launched, seq_done;
  logic [SW-1:0] step;
  ddr_cmd_e      enc_cmd;
  logic [BA_W-1:0]   enc_ba;
  logic [ADDR_W-1:0] enc_addr;

  ddr2i_gap_timer #(.GAP_CYC(GAP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(fire), .expired(expired)
  );

  ddr2i_step_ctrl #(.STEPS(NUM_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .expired(expired),
    .fire(fire), .issue(issue), .step(step), .launched(launched), .done(seq_done)
  );

  ddr2i_mode_enc #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .BURST_LEN(BURST_LEN), .BURST_INTLV(BURST_INTLV),
    .CAS_LAT(CAS_LAT), .WR_REC(WR_REC), .PD_SLOW_EXIT(PD_SLOW_EXIT),
    .DLL_DISABLE(DLL_DISABLE), .DRIVE_REDUCE(DRIVE_REDUCE), .RTT_CODE(RTT_CODE),
    .ADD_LAT(ADD_LAT), .DQSN_DISABLE(DQSN_DISABLE), .RDQS_ENABLE(RDQS_ENABLE),
    .OUT_DISABLE(OUT_DISABLE), .SRT_FAST(SRT_FAST)
  ) u_enc (
    .step_info(step_of(int'(step))), .cmd(enc_cmd), .ba(enc_ba), .addr(enc_addr)
  );

  // Output register stage: every pin changes one edge after the decision
  logic [2:0] rcw_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke   <= 1'b0;
      cs_n  <= 1'b1;
      rcw_q <= CMD_NOP;
      ba    <= '0;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      cke  <= 1'b1;
      done <= seq_done;
      cs_n <= !launched;
      if (issue) begin
        rcw_q <= enc_cmd;
        ba    <= enc_ba;
        addr  <= enc_addr;
      end else begin
        rcw_q <= CMD_NOP;
        ba    <= '0;
        addr  <= '0;
      end
    end
  end

  assign {ras_n, cas_n, we_n} = rcw_q;
endmodule

// File: rtl/ddr2i_init_chk.sv
module ddr2i_init_chk #(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int GAP_CYC = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GSAT = GW'(GAP_CYC);

  logic cmd_live, pre_live;
  assign cmd_live = !cs_n && !(ras_n && cas_n && we_n);
  assign pre_live = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);

  logic [GW-1:0] since_q;
  logic [3:0]    ncmd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= GSAT;
      ncmd_q  <= '0;
    end else begin
      if (cmd_live)             since_q <= GW'(1);
      else if (since_q != GSAT) since_q <= since_q + 1'b1;
      if (cmd_live && ncmd_q != 4'hF) ncmd_q <= ncmd_q + 1'b1;
    end
  end

  p_cke_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cs_n && ras_n && cas_n && we_n));
  p_pre_a10_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_live |-> (addr == ADDR_W'(1 << 10) && ba == '0));
  p_cmd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_live |-> (since_q == GSAT));
  p_cmd_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (ncmd_q == 4'd11));
  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ras_n && cas_n && we_n));
endmodule

bind ddr2i_init_seq ddr2i_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
);

// File: tb/ddr2i_init_seq_tb_top.sv
module ddr2i_init_seq_tb_top;
  localparam int GAP = 15;
  localparam int AW  = 13;
  localparam int BW  = 2;
  localparam logic [17:0] NOPV = {3'b111, 2'b00, 13'h0000};

  // {ras_n,cas_n,we_n, ba, addr} per step
  localparam logic [17:0] EXP [11] = '{
    {3'b010, 2'd0, 13'h0400},  // precharge all
    {3'b000, 2'd2, 13'h0000},  // MR2
    {3'b000, 2'd3, 13'h0000},  // MR3
    {3'b000, 2'd1, 13'h0000},  // MR1 OCD exit
    {3'b000, 2'd0, 13'h0532},  // MR0 DLL reset
    {3'b010, 2'd0, 13'h0400},  // precharge all
    {3'b001, 2'd0, 13'h0000},  // refresh
    {3'b001, 2'd0, 13'h0000},  // refresh
    {3'b000, 2'd0, 13'h0432},  // MR0 no DLL reset
    {3'b000, 2'd1, 13'h0380},  // MR1 OCD default
    {3'b000, 2'd1, 13'h0000}   // MR1 OCD exit
  };
  localparam string TAG [11] = '{
    "R3 R5", "R3 R8", "R3 R8", "R3 R7", "R3 R6", "R3 R5",
    "R3 R4", "R3 R4", "R3 R6", "R3 R7", "R3 R7"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int nvec = 0;
  int nbad = 0;
  int pos  = 0;

  always #4 clk = ~clk;

  ddr2i_init_seq #(.ADDR_W(AW), .BA_W(BW), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
  );

  function automatic logic [17:0] pins();
    return {ras_n, cas_n, we_n, ba, addr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch();
    @(negedge clk); start = 1'b1;
    @(posedge clk);               // edge E0
    @(negedge clk); start = 1'b0;
    pos = 0;
  endtask

  task automatic go_to(input int n);
    repeat (n - pos) @(posedge clk);
    @(negedge clk);
    pos = n;
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog R9 actual=no-finish expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 cke/cs_n/done", {cke, cs_n, done}, 3'b010);
    chk("R1 pins", pins(), NOPV);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 cke after release", cke, 1'b1);
    repeat (5) @(negedge clk);
    chk("R2 idle without start", {cs_n, pins()}, {1'b1, NOPV});

    launch();
    chk("R2 first cycle after E0 still idle", {cs_n, pins()}, {1'b1, NOPV});
    for (int k = 0; k < 11; k++) begin
      go_to(1 + k * GAP);
      chk(TAG[k], {cs_n, pins()}, {1'b0, EXP[k]});
      if (k == 4) start = 1'b1;   // R10: ignored while running
      go_to(2 + k * GAP);
      start = 1'b0;
      chk("R4 NOP after command", {cs_n, pins(), done}, {1'b0, NOPV, 1'b0});
    end
    go_to(11 * GAP);
    chk("R9 done not early", done, 1'b0);
    go_to(11 * GAP + 1);
    chk("R9 done rises", {done, cs_n, pins()}, {1'b1, 1'b0, NOPV});

    // R10: start after done
    start = 1'b1;
    go_to(11 * GAP + 2);
    start = 1'b0;
    begin
      logic bad;
      bad = 1'b0;
      for (int i = 0; i < 3 * GAP; i++) begin
        go_to(11 * GAP + 3 + i);
        if ({done, cs_n, pins(), cke} !== {1'b1, 1'b0, NOPV, 1'b1}) bad = 1'b1;
      end
      chk("R10 R9 R11 quiet and held after done", bad, 1'b0);
    end

    // Reset in done state, then relaunch
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears done", {cke, cs_n, done, pins()}, {1'b0, 1'b1, 1'b0, NOPV});
    rst_n = 1'b1;
    launch();
    chk("R2 relaunch first cycle idle", cs_n, 1'b1);
    go_to(1);
    chk("R2 R5 relaunch precharge", {cs_n, pins()}, {1'b0, EXP[0]});
    go_to(1 + GAP);
    chk("R3 R8 relaunch second step", {cs_n, pins()}, {1'b0, EXP[1]});

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule